// File: doc/BRIEF.md
# DMA Channel Address Sequencer with Periodic Source Rewind

This block is the address and count engine of one DMA channel. Software loads a source address, a destination address, a unit count and a control word. Each time the channel is enabled, a request is present and the bus side reports a finished transfer unit, the block steps both addresses by the unit size (1, 2 or 4 bytes) in their chosen directions. It also lowers the remaining count by one. When the count reaches zero it raises an end flag and stops issuing units until software acknowledges the flag.

When source rewind is enabled, the block counts completed units in groups of four. After the fourth unit of each group, the working source address is reloaded from a shadow copy. The shadow copy is captured on every software write to the source register. This lets a short table be read over and over into a fixed destination. The same group boundary produces a one-cycle bus-release pulse.

The group counter has its own clearing events. These are: loss of master enable, loss of channel enable, the end flag, NMI, an address error, standby, and reset. None of these events disturbs the address or count registers.

Top module: `dma_rewind_chan`

## Requirements
- R1: After reset, both addresses, the count, the end flag, the unit-valid output, the bus-release pulse and the misfit flag are all zero, and the group position is at the start of a group.
- R2: A completed unit moves the source address by the unit size. The size is set by control bits [3:2]: 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes. The direction is set by control bits [5:4]: 0 holds the address, 1 increments it, 2 decrements it.
- R3: The destination address follows control bits [7:6], using the same direction codes. Code 0 keeps it fixed while the source moves.
- R4: With rewind enabled (control bit 1), the fourth completed unit of a group loads the source address with the value most recently written to the source register (write select 0), instead of stepping it.
- R5: The count (write select 2) drops by exactly one per completed unit, whether rewind is on or off.
- R6: The end flag sets on the unit that brings the count to zero. While the flag is set, the unit-valid output stays low. A control write (write select 3) with bit 8 set clears the flag.
- R7: The group position returns to the start of a group on any of these events: master enable low, channel enable (control bit 0) low, end flag, NMI, address error, or standby. These events leave the source, destination and count unchanged.
- R8: The bus-release output is a one-cycle pulse in the cycle after the fourth completed unit of each group.
- R9: The misfit output is high while rewind is enabled and the count is not a multiple of four.
- R10: The unit-valid output is high only when all of the following hold: request is high, master enable is high, channel enable is set, standby is low, the end flag is clear, and the count is non-zero. A unit completes when unit-valid and unit-done are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 source, 1 destination, 2 count, 3 control |
| wr_data_i | input | ADDR_W | Write data |
| master_en_i | input | 1 | Global DMA enable |
| req_i | input | 1 | Transfer request |
| unit_done_i | input | 1 | Current unit finished on the bus |
| addr_err_i | input | 1 | Address error event |
| nmi_i | input | 1 | Non-maskable interrupt event |
| standby_i | input | 1 | Standby mode |
| src_addr_o | output | ADDR_W | Working source address |
| dst_addr_o | output | ADDR_W | Working destination address |
| count_o | output | CNT_W | Remaining unit count |
| xfer_valid_o | output | 1 | Channel is issuing a unit |
| end_flag_o | output | 1 | Count reached zero |
| bus_release_o | output | 1 | Group-boundary bus release pulse |
| count_misfit_o | output | 1 | Rewind on and count not a multiple of four |

## Verification
The hardest situation to reach is a group counter that has been cleared partway through a group. From the ports, this only shows up as a shift in where the next rewind lands. For each clearing event, the stimulus runs two units, applies the event for one cycle, and checks that source, destination and count did not move. It then runs three more units with no rewind and no release, and finally a fourth unit that rewinds. A counter that missed the clear would rewind two units too early.

// File: rtl/dma_rw_pkg.sv
package dma_rw_pkg;

   typedef enum logic [1:0] {
      AM_HOLD = 2'd0,
      AM_UP   = 2'd1,
      AM_DOWN = 2'd2,
      AM_RSVD = 2'd3
   } addr_dir_e;

   typedef enum logic [1:0] {
      WS_SRC  = 2'd0,
      WS_DST  = 2'd1,
      WS_CNT  = 2'd2,
      WS_CTRL = 2'd3
   } wr_sel_e;

   typedef struct packed {
      logic      end_ack;
      addr_dir_e dst_dir;
      addr_dir_e src_dir;
      logic [1:0] unit_sz;
      logic      rewind_en;
      logic      chan_en;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

   // Bytes per unit; reserved size code behaves as 4 bytes.
   function automatic logic [2:0] unit_bytes(input logic [1:0] sz);
      case (sz)
         2'd0:    unit_bytes = 3'd1;
         2'd1:    unit_bytes = 3'd2;
         default: unit_bytes = 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/dma_rw_addr_unit.sv
module dma_rw_addr_unit
   import dma_rw_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter bit HAS_REWIND = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] wr_data_i,
   input  logic              step_i,
   input  logic              rewind_i,
   input  addr_dir_e         dir_i,
   input  logic [2:0]        stride_i,
   output logic [ADDR_W-1:0] addr_o
);

   localparam int PAD_W = ADDR_W - 3;

   if (ADDR_W < 8) begin : g_bad_width
      $error("dma_rw_addr_unit: ADDR_W must be at least 8");
   end

   logic [ADDR_W-1:0] stride_ext;
   logic [ADDR_W-1:0] stepped;
   logic [ADDR_W-1:0] restart;
   logic              rewind_eff;

   assign stride_ext = {{PAD_W{1'b0}}, stride_i};

   always_comb begin
      case (dir_i)
         AM_UP:   stepped = addr_o + stride_ext;
         AM_DOWN: stepped = addr_o - stride_ext;
         default: stepped = addr_o;
      endcase
   end

   if (HAS_REWIND) begin : g_rewind
      logic [ADDR_W-1:0] shadow_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    shadow_q <= '0;
         else if (wr_i) shadow_q <= wr_data_i;
      end
      assign restart    = shadow_q;
      assign rewind_eff = rewind_i;

      assert_rewind_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (rewind_i && step_i && !wr_i) |=> (addr_o == $past(shadow_q)));
   end else begin : g_plain
      logic unused_rewind;
      assign unused_rewind = rewind_i;
      assign restart       = '0;
      assign rewind_eff    = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   addr_o <= '0;
      else if (wr_i)                addr_o <= wr_data_i;
      else if (step_i && rewind_eff) addr_o <= restart;
      else if (step_i)              addr_o <= stepped;
   end

   assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !wr_i && !rewind_i && dir_i == AM_UP)
      |=> (addr_o == $past(addr_o) + $past(stride_ext)));

   assert_hold_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_i && dir_i == AM_HOLD && !rewind_i) |=> $stable(addr_o));

endmodule

// File: rtl/dma_rw_group_ctr.sv
module dma_rw_group_ctr #(
   parameter int GROUP_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic adv_i,
   output logic wrap_o,
   output logic at_start_o
);

   localparam int GRP_W = (GROUP_LEN > 1) ? $clog2(GROUP_LEN) : 1;
   localparam logic [GRP_W-1:0] LAST = GRP_W'(GROUP_LEN - 1);

   if (GROUP_LEN < 2 || (GROUP_LEN & (GROUP_LEN - 1)) != 0) begin : g_bad_len
      $error("dma_rw_group_ctr: GROUP_LEN must be a power of two of at least 2");
   end

   logic [GRP_W-1:0] pos_q;

   assign wrap_o     = adv_i && (pos_q == LAST);
   assign at_start_o = (pos_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pos_q <= '0;
      else if (clear_i) pos_q <= '0;
      else if (adv_i)   pos_q <= pos_q + {{(GRP_W-1){1'b0}}, 1'b1};
   end

   assert_clear_restarts_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> at_start_o);

endmodule

// File: rtl/dma_rw_count_unit.sv
module dma_rw_count_unit #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [CNT_W-1:0] wr_data_i,
   input  logic             dec_i,
   input  logic             ack_i,
   output logic [CNT_W-1:0] count_o,
   output logic             last_o,
   output logic             end_o
);

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   if (CNT_W < 2) begin : g_bad_cnt
      $error("dma_rw_count_unit: CNT_W must be at least 2");
   end

   assign last_o = dec_i && (count_o == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count_o <= '0;
      else if (wr_i)  count_o <= wr_data_i;
      else if (dec_i) count_o <= count_o - ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      end_o <= 1'b0;
      else if (last_o) end_o <= 1'b1;
      else if (ack_i)  end_o <= 1'b0;
   end

   assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_i && !wr_i) |=> (count_o == $past(count_o) - ONE));

   assert_end_on_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_i && !wr_i && count_o == ONE) |=> end_o);

endmodule

// File: rtl/dma_rewind_chan.sv
module dma_rewind_chan
   import dma_rw_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int CNT_W     = 16,
   parameter int GROUP_LEN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [1:0]        wr_sel_i,
   input  logic [ADDR_W-1:0] wr_data_i,
   input  logic              master_en_i,
   input  logic              req_i,
   input  logic              unit_done_i,
   input  logic              addr_err_i,
   input  logic              nmi_i,
   input  logic              standby_i,
   output logic [ADDR_W-1:0] src_addr_o,
   output logic [ADDR_W-1:0] dst_addr_o,
   output logic [CNT_W-1:0]  count_o,
   output logic              xfer_valid_o,
   output logic              end_flag_o,
   output logic              bus_release_o,
   output logic              count_misfit_o
);

   localparam int GRP_W = $clog2(GROUP_LEN);

   if (CNT_W > ADDR_W) begin : g_bad_cnt
      $error("dma_rewind_chan: CNT_W must not exceed ADDR_W");
   end
   if (ADDR_W < CTRL_W) begin : g_bad_ctrl
      $error("dma_rewind_chan: ADDR_W too narrow for control word");
   end
   if (GRP_W < 1 || GRP_W > CNT_W) begin : g_bad_grp
      $error("dma_rewind_chan: GROUP_LEN out of range for CNT_W");
   end

   // Register write decode
   logic wr_src, wr_dst, wr_cnt, wr_ctrl;
   assign wr_src  = wr_en_i && (wr_sel_i == WS_SRC);
   assign wr_dst  = wr_en_i && (wr_sel_i == WS_DST);
   assign wr_cnt  = wr_en_i && (wr_sel_i == WS_CNT);
   assign wr_ctrl = wr_en_i && (wr_sel_i == WS_CTRL);

   ctrl_t ctrl_q;
   ctrl_t ctrl_wr;
   assign ctrl_wr = ctrl_t'(wr_data_i[CTRL_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= ctrl_wr;
   end

   if (ADDR_W > CTRL_W) begin : g_unused_hi
      logic unused_ctrl_hi;
      assign unused_ctrl_hi = ^wr_data_i[ADDR_W-1:CTRL_W];
   end
   if (CNT_W < ADDR_W && ADDR_W <= CTRL_W) begin : g_unused_cnt
      logic unused_cnt_hi;
      assign unused_cnt_hi = ^wr_data_i[ADDR_W-1:CNT_W];
   end

   // Issue and completion
   logic ready, done, last_unit, wrap, grp_clear, grp_start;
   logic [2:0] stride;

   assign ready        = master_en_i && ctrl_q.chan_en && !standby_i
                         && !end_flag_o && (count_o != '0);
   assign xfer_valid_o = ready && req_i;
   assign done         = xfer_valid_o && unit_done_i;
   assign stride       = unit_bytes(ctrl_q.unit_sz);

   assign grp_clear = !master_en_i || !ctrl_q.chan_en || end_flag_o || last_unit
                      || nmi_i || addr_err_i || standby_i;

   dma_rw_group_ctr #(.GROUP_LEN(GROUP_LEN)) u_group (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (grp_clear),
      .adv_i      (done),
      .wrap_o     (wrap),
      .at_start_o (grp_start)
   );

   dma_rw_addr_unit #(.ADDR_W(ADDR_W), .HAS_REWIND(1'b1)) u_src (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (wr_src),
      .wr_data_i (wr_data_i),
      .step_i    (done),
      .rewind_i  (wrap && ctrl_q.rewind_en),
      .dir_i     (ctrl_q.src_dir),
      .stride_i  (stride),
      .addr_o    (src_addr_o)
   );

   dma_rw_addr_unit #(.ADDR_W(ADDR_W), .HAS_REWIND(1'b0)) u_dst (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (wr_dst),
      .wr_data_i (wr_data_i),
      .step_i    (done),
      .rewind_i  (1'b0),
      .dir_i     (ctrl_q.dst_dir),
      .stride_i  (stride),
      .addr_o    (dst_addr_o)
   );

   dma_rw_count_unit #(.CNT_W(CNT_W)) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (wr_cnt),
      .wr_data_i (wr_data_i[CNT_W-1:0]),
      .dec_i     (done),
      .ack_i     (wr_ctrl && ctrl_wr.end_ack),
      .count_o   (count_o),
      .last_o    (last_unit),
      .end_o     (end_flag_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_release_o <= 1'b0;
      else        bus_release_o <= wrap;
   end

   assign count_misfit_o = ctrl_q.rewind_en && (count_o[GRP_W-1:0] != '0);

   // Checks beside the control logic
   assert_end_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      end_flag_o |-> !xfer_valid_o);

   assert_release_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_release_o |=> !bus_release_o);

   assert_nmi_keeps_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_i && !wr_en_i) |=> $stable(count_o));

   assert_err_keeps_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_err_i && !wr_en_i) |=> $stable(src_addr_o));

   assert_release_at_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_release_o |-> grp_start);

   assert_valid_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid_o |-> (req_i && master_en_i && !standby_i && count_o != '0));

endmodule

// File: tb/dma_rewind_chan_bench.sv
module dma_rewind_chan_bench;

   localparam int AW = 32;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en_i = 1'b0;
   logic [1:0]    wr_sel_i = '0;
   logic [AW-1:0] wr_data_i = '0;
   logic          master_en_i = 1'b0;
   logic          req_i = 1'b0;
   logic          unit_done_i = 1'b0;
   logic          addr_err_i = 1'b0;
   logic          nmi_i = 1'b0;
   logic          standby_i = 1'b0;
   logic [AW-1:0] src_addr_o, dst_addr_o;
   logic [CW-1:0] count_o;
   logic          xfer_valid_o, end_flag_o, bus_release_o, count_misfit_o;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   dma_rewind_chan #(.ADDR_W(AW), .CNT_W(CW), .GROUP_LEN(4)) u_dma_rewind_chan (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
      .wr_data_i(wr_data_i), .master_en_i(master_en_i), .req_i(req_i),
      .unit_done_i(unit_done_i), .addr_err_i(addr_err_i), .nmi_i(nmi_i),
      .standby_i(standby_i), .src_addr_o(src_addr_o), .dst_addr_o(dst_addr_o),
      .count_o(count_o), .xfer_valid_o(xfer_valid_o), .end_flag_o(end_flag_o),
      .bus_release_o(bus_release_o), .count_misfit_o(count_misfit_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Control word: bit0 channel enable, bit1 rewind, [3:2] size, [5:4] src dir, [7:6] dst dir, bit8 end ack
   function automatic logic [31:0] mkctrl(input bit en, input bit rw, input int sz,
                                          input int sd, input int dd);
      return {23'd0, 1'b1, dd[1:0], sd[1:0], sz[1:0], rw, en};
   endfunction

   task automatic wr(input logic [1:0] sel, input logic [31:0] data);
      @(negedge clk);
      wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   task automatic setup(input logic [31:0] s, input logic [31:0] d, input logic [31:0] n,
                        input logic [31:0] c);
      wr(2'd3, 32'h100);
      wr(2'd0, s);
      wr(2'd1, d);
      wr(2'd2, n);
      wr(2'd3, c);
   endtask

   task automatic unit();
      @(negedge clk);
      req_i = 1'b1; unit_done_i = 1'b1;
      @(negedge clk);
      req_i = 1'b0; unit_done_i = 1'b0;
   endtask

   task automatic test_reset();
      chk("R1 src", src_addr_o, 0);
      chk("R1 dst", dst_addr_o, 0);
      chk("R1 count", 32'(count_o), 0);
      chk("R1 end", 32'(end_flag_o), 0);
      chk("R1 valid", 32'(xfer_valid_o), 0);
      chk("R1 release", 32'(bus_release_o), 0);
      chk("R1 misfit", 32'(count_misfit_o), 0);
   endtask

   task automatic test_half_rewind();
      setup(32'h1000, 32'h2000, 8, mkctrl(1, 1, 1, 1, 0));
      chk("R9 count 8 fits", 32'(count_misfit_o), 0);
      for (int k = 1; k <= 8; k++) begin
         unit();
         chk("R2/R4 src", src_addr_o, (k % 4 == 0) ? 32'h1000 : 32'h1000 + 2 * (k % 4));
         chk("R3 dst fixed", dst_addr_o, 32'h2000);
         chk("R5 count", 32'(count_o), 32'(8 - k));
         chk("R8 release", 32'(bus_release_o), (k % 4 == 0) ? 1 : 0);
      end
      @(negedge clk);
      chk("R8 pulse one cycle", 32'(bus_release_o), 0);
      chk("R6 end set", 32'(end_flag_o), 1);
      req_i = 1'b1;
      #1 chk("R6 valid low at end", 32'(xfer_valid_o), 0);
      req_i = 1'b0;
   endtask

   task automatic test_end_ack();
      wr(2'd3, mkctrl(1, 1, 1, 1, 0));
      chk("R6 end cleared", 32'(end_flag_o), 0);
      req_i = 1'b1;
      #1 chk("R10 zero count blocks", 32'(xfer_valid_o), 0);
      req_i = 1'b0;
      wr(2'd2, 4);
      req_i = 1'b1;
      #1 chk("R10 valid with count", 32'(xfer_valid_o), 1);
      req_i = 1'b0;
   endtask

   task automatic test_sizes();
      setup(32'h40, 32'h80, 4, mkctrl(1, 1, 0, 1, 1));
      for (int k = 1; k <= 4; k++) begin
         unit();
         chk("R2/R4 byte src", src_addr_o, (k == 4) ? 32'h40 : 32'h40 + k);
         chk("R3 byte dst up", dst_addr_o, 32'h80 + k);
      end
      setup(32'h100, 32'h300, 4, mkctrl(1, 1, 2, 1, 0));
      for (int k = 1; k <= 4; k++) begin
         unit();
         chk("R2/R4 word src", src_addr_o, (k == 4) ? 32'h100 : 32'h100 + 4 * k);
      end
      setup(32'h100, 32'h300, 4, mkctrl(1, 0, 2, 1, 0));
      for (int k = 1; k <= 4; k++) unit();
      chk("R4 no rewind when off", src_addr_o, 32'h110);
      chk("R5 count without rewind", 32'(count_o), 0);
   endtask

   task automatic test_down();
      setup(32'h200, 32'h300, 2, mkctrl(1, 0, 2, 2, 2));
      unit();
      chk("R2 src down", src_addr_o, 32'h1FC);
      chk("R3 dst down", dst_addr_o, 32'h2FC);
   endtask

   task automatic test_group_clear(input int kind);
      setup(32'h1000, 32'h2000, 12, mkctrl(1, 1, 1, 1, 0));
      unit(); unit();
      chk("R7 pre src", src_addr_o, 32'h1004);
      case (kind)
         0: begin @(negedge clk); nmi_i = 1'b1; @(negedge clk); nmi_i = 1'b0; end
         1: begin @(negedge clk); addr_err_i = 1'b1; @(negedge clk); addr_err_i = 1'b0; end
         2: begin @(negedge clk); standby_i = 1'b1; @(negedge clk); standby_i = 1'b0; end
         3: begin @(negedge clk); master_en_i = 1'b0; @(negedge clk); master_en_i = 1'b1; end
         default: begin
            wr(2'd3, mkctrl(0, 1, 1, 1, 0));
            wr(2'd3, mkctrl(1, 1, 1, 1, 0));
         end
      endcase
      chk("R7 src kept", src_addr_o, 32'h1004);
      chk("R7 dst kept", dst_addr_o, 32'h2000);
      chk("R7 count kept", 32'(count_o), 10);
      for (int k = 1; k <= 3; k++) begin
         unit();
         chk("R7 no early rewind", src_addr_o, 32'h1004 + 2 * k);
         chk("R7 no early release", 32'(bus_release_o), 0);
      end
      unit();
      chk("R7 rewind after fresh group", src_addr_o, 32'h1000);
      chk("R8 release after fresh group", 32'(bus_release_o), 1);
   endtask

   task automatic test_misfit_and_gate();
      setup(32'h0, 32'h0, 6, mkctrl(1, 1, 0, 1, 0));
      chk("R9 misfit 6", 32'(count_misfit_o), 1);
      wr(2'd3, mkctrl(1, 0, 0, 1, 0));
      chk("R9 misfit off", 32'(count_misfit_o), 0);
      @(negedge clk);
      req_i = 1'b1; standby_i = 1'b1;
      #1 chk("R10 standby gate", 32'(xfer_valid_o), 0);
      standby_i = 1'b0; master_en_i = 1'b0;
      #1 chk("R10 master gate", 32'(xfer_valid_o), 0);
      master_en_i = 1'b1;
      #1 chk("R10 valid", 32'(xfer_valid_o), 1);
      req_i = 1'b0;
      #1 chk("R10 no req", 32'(xfer_valid_o), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      master_en_i = 1'b1;
      @(negedge clk);
      test_half_rewind();
      test_end_ack();
      test_sizes();
      test_down();
      for (int kind = 0; kind < 5; kind++) test_group_clear(kind);
      test_misfit_and_gate();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule